// File: doc/BRIEF.md
# Per-Read-Port Distributed Register Store

This block holds the operand values of a statically scheduled datapath built from several functional units. There is no single many-ported register file. Each read port owns a private memory with one read port and one write port, here called a funnel file. Each unit produces one result per cycle. A distribution network copies that result into any set of funnel files, at a separate address in each. A read port can only see its own funnel file.

A reserved read address returns the value being delivered to that funnel file in the same cycle, so a consumer can pick up a fresh result without waiting for it to be stored. A small one-bit guard store lets each unit make its writeback conditional. The guard store has its own write port.

The compiler's schedule is trusted to avoid two writers landing on one funnel file in one cycle. If that happens anyway, a fixed priority picks the winner and a sticky flag records the event.

Top module: `funnel_fabric`

## Requirements
- R1: After reset every `rd_data` lane reads zero, every funnel file entry holds zero, `collide_err` is 0, and every guard entry except entry 0 is false.
- R2: When unit u has an effective write and bit `u*NR+f` of `wr_dest` is set, `wr_data` lane u is stored in funnel file f at the address in field `(u*NR+f)` of `wr_addr`. One result may be stored into several files in the same cycle. A read address presented in cycle t returns the stored word in cycle t+1.
- R3: Read port f returns only words from funnel file f. A write aimed at other files leaves the value read through port f unchanged.
- R4: A read address with all AWM bits set is the forwarding code. The port then returns, one cycle later, the data written into its own file in the same cycle, or zero when nothing is written to that file.
- R5: Funnel file f has 2^w entries, where w is nibble f of `FAW`. Only the low w address bits select an entry, so addresses that differ above bit w-1 alias.
- R6: A unit's write is effective only if `wr_en` is set and its guard address is 0 (always true) or names a guard entry holding 1. A guarded-off write changes no funnel file.
- R7: A guard write (`gw_en`) to a nonzero address stores `gw_val` at the clock edge. The new value governs writebacks from the next cycle on. Guard writes to address 0 are ignored.
- R8: When two or more effective writes target one funnel file in one cycle, the lowest-numbered unit's data and address are used. `collide_err` rises on the next cycle and stays 1 until reset.
- R9: A read of a non-forwarding address that is being written in the same cycle returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NU | Result valid, one bit per unit |
| wr_data | input | NU*DW | Result word, one lane per unit |
| wr_dest | input | NU*NR | Destination set, bit u*NR+f selects file f for unit u |
| wr_addr | input | NU*NR*AWM | Per-unit, per-file write address |
| wr_guard | input | NU*GW | Guard store address for each unit |
| gw_en | input | 1 | Guard store write enable |
| gw_addr | input | GW | Guard store write address |
| gw_val | input | 1 | Guard value to store |
| rd_addr | input | NR*AWM | Read address, one field per read port |
| rd_data | output | NR*DW | Read data, one lane per read port, one cycle after address |
| collide_err | output | 1 | Sticky flag for a write collision on some funnel file |

## Verification
A corrupted funnel file entry stays invisible until some port reads that exact address, and then it shows one cycle later on that port's lane only. For this reason the random stimulus reads every port on every cycle, with scattered addresses. A wrong guard bit or a wrong priority choice leaves no direct mark. It shows up as a missing or extra stored word at the next read of that entry. A lost or spurious collision shows up one cycle after the clashing writes, on `collide_err`.

// File: rtl/funnel_fabric.sv
module funnel_fabric #(
  parameter int NU  = 6,
  parameter int NR  = 13,
  parameter int DW  = 32,
  parameter int AWM = 4,
  parameter int GW  = 3,
  parameter logic [63:0] FAW = 64'h0004_3434_3434_3434
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NU-1:0]         wr_en,
  input  logic [NU*DW-1:0]      wr_data,
  input  logic [NU*NR-1:0]      wr_dest,
  input  logic [NU*NR*AWM-1:0]  wr_addr,
  input  logic [NU*GW-1:0]      wr_guard,
  input  logic                  gw_en,
  input  logic [GW-1:0]         gw_addr,
  input  logic                  gw_val,
  input  logic [NR*AWM-1:0]     rd_addr,
  output logic [NR*DW-1:0]      rd_data,
  output logic                  collide_err
);
  localparam int GD = 2**GW;

  logic [GD-1:0] gmem;
  logic [NU-1:0] eff;
  logic [NR-1:0] dup_v;
  logic          unused_addr_bits;

  assign unused_addr_bits = ^wr_addr;

  always_comb
    for (int u = 0; u < NU; u++) begin
      eff[u] = wr_en[u] &&
               (wr_guard[u*GW +: GW] == '0 || gmem[wr_guard[u*GW +: GW]]);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gmem        <= '0;
      collide_err <= 1'b0;
    end else begin
      if (gw_en && gw_addr != '0) gmem[gw_addr] <= gw_val;
      if (|dup_v) collide_err <= 1'b1;
    end

  for (genvar f = 0; f < NR; f++) begin : g_ff
    localparam int AW  = int'(FAW[f*4 +: 4]);
    localparam int DEP = 2**AW;

    logic [DW-1:0] mem [DEP];
    logic [DW-1:0] wd, q;
    logic [AW-1:0] wa;
    logic          hit, dup;
    logic [AWM-1:0] ra;

    assign ra = rd_addr[f*AWM +: AWM];

    always_comb begin
      hit = 1'b0;
      dup = 1'b0;
      wd  = '0;
      wa  = '0;
      for (int u = 0; u < NU; u++)
        if (eff[u] && wr_dest[u*NR+f]) begin
          if (hit) dup = 1'b1;
          else begin
            hit = 1'b1;
            wd  = wr_data[u*DW +: DW];
            wa  = wr_addr[(u*NR+f)*AWM +: AW];
          end
        end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        q <= '0;
        for (int i = 0; i < DEP; i++) mem[i] <= '0;
      end else begin
        if (hit) mem[wa] <= wd;
        q <= (&ra) ? (hit ? wd : '0) : mem[ra[AW-1:0]];
      end

    assign rd_data[f*DW +: DW] = q;
    assign dup_v[f] = dup;
  end
endmodule

module funnel_fabric_chk #(
  parameter int NU  = 6,
  parameter int NR  = 13,
  parameter int DW  = 32,
  parameter int AWM = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NU-1:0]       wr_en,
  input logic [NR*AWM-1:0]   rd_addr,
  input logic [NR*DW-1:0]    rd_data,
  input logic                collide_err
);
  p_sticky_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    collide_err |=> collide_err);

  p_err_needs_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(collide_err) |-> $past($countones(wr_en) >= 2));

  p_fwd_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((&rd_addr[AWM-1:0]) && wr_en == '0) |=> rd_data[DW-1:0] == '0);

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0 && $past(wr_en) == '0 && $stable(rd_addr)) |=> $stable(rd_data));
endmodule

bind funnel_fabric funnel_fabric_chk #(.NU(NU), .NR(NR), .DW(DW), .AWM(AWM)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .collide_err(collide_err));

// File: tb/sim_funnel_fabric.sv
module sim_funnel_fabric;
  localparam int NU = 6, NR = 13, DW = 32, AWM = 4, GW = 3;
  localparam logic [63:0] FAW = 64'h0004_3434_3434_3434;

  logic clk = 0, rst_n = 0;
  logic [NU-1:0]        wr_en = '0;
  logic [NU*DW-1:0]     wr_data = '0;
  logic [NU*NR-1:0]     wr_dest = '0;
  logic [NU*NR*AWM-1:0] wr_addr = '0;
  logic [NU*GW-1:0]     wr_guard = '0;
  logic                 gw_en = 0, gw_val = 0;
  logic [GW-1:0]        gw_addr = '0;
  logic [NR*AWM-1:0]    rd_addr = '0;
  logic [NR*DW-1:0]     rd_data;
  logic                 collide_err;

  int vecs = 0, bad = 0;
  logic [DW-1:0] mdl [NR][16];
  logic [7:0]    gm;
  logic          merr;

  always #2 clk = ~clk;

  funnel_fabric u0 (.*);

  function automatic int fw(int f);
    return int'(FAW[f*4 +: 4]);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    wr_en = '0; wr_dest = '0; gw_en = 0; wr_guard = '0;
  endtask

  task automatic wr(int u, int f, int a, logic [DW-1:0] d, int g);
    wr_en[u] = 1'b1;
    wr_data[u*DW +: DW] = d;
    wr_dest[u*NR+f] = 1'b1;
    wr_addr[(u*NR+f)*AWM +: AWM] = AWM'(a);
    wr_guard[u*GW +: GW] = GW'(g);
  endtask

  task automatic step(string tag);
    logic [DW-1:0] exp [NR];
    logic [NR-1:0] hit;
    logic [DW-1:0] wd [NR];
    int wa [NR];
    logic dupany;
    dupany = 0;
    for (int f = 0; f < NR; f++) begin
      hit[f] = 0; wd[f] = '0; wa[f] = 0;
      for (int u = 0; u < NU; u++) begin
        int g;
        g = int'(wr_guard[u*GW +: GW]);
        if (wr_en[u] && (g == 0 || gm[g]) && wr_dest[u*NR+f]) begin
          if (hit[f]) dupany = 1;
          else begin
            hit[f] = 1; wd[f] = wr_data[u*DW +: DW];
            wa[f] = int'(wr_addr[(u*NR+f)*AWM +: AWM]) % (1 << fw(f));
          end
        end
      end
      if (&rd_addr[f*AWM +: AWM]) exp[f] = hit[f] ? wd[f] : '0;
      else exp[f] = mdl[f][int'(rd_addr[f*AWM +: AWM]) % (1 << fw(f))];
    end
    for (int f = 0; f < NR; f++) if (hit[f]) mdl[f][wa[f]] = wd[f];
    if (gw_en && gw_addr != 0) gm[gw_addr] = gw_val;
    @(negedge clk);
    for (int f = 0; f < NR; f++)
      chk((&rd_addr[f*AWM +: AWM]) ? "R4 fwd" : tag, rd_data[f*DW +: DW], exp[f]);
    merr = merr | dupany;
    chk("R8 err", {31'd0, collide_err}, {31'd0, merr});
  endtask

  function automatic void rd(int f, int a);
    rd_addr[f*AWM +: AWM] = AWM'(a);
  endfunction

  initial begin
    #(200000*4);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int f = 0; f < NR; f++) for (int a = 0; a < 16; a++) mdl[f][a] = '0;
    gm = '0; merr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    step("R1 reset");
    // R2/R3: one result copied into three files at different addresses
    wr(2, 0, 1, 32'hA5A5_0001, 0); wr(2, 5, 2, 32'hA5A5_0001, 0); wr(2, 12, 3, 32'hA5A5_0001, 0);
    step("R2 multicast");
    clear_in(); rd(0, 1); rd(5, 2); rd(12, 3); rd(1, 1); rd(4, 2);
    step("R2 R3 readback");
    // R4: forward on file 6 with a write present
    wr(3, 6, 4, 32'hF0F0_1234, 0); rd(6, 15);
    step("R4 fwd");
    clear_in(); rd(6, 4);
    step("R4 stored");
    // R5: file 1 is 8 deep, address 10 aliases 2
    wr(1, 1, 2, 32'h0000_BEEF, 0); rd(1, 10);
    step("R9 old");
    clear_in();
    step("R5 alias");
    // R6: guard entry 3 false after reset
    wr(0, 2, 5, 32'hDEAD_0006, 3); rd(2, 5);
    step("R6 guarded");
    clear_in();
    step("R6 suppressed");
    // R7: guard write lands at the edge, not usable in the same cycle
    gw_en = 1; gw_addr = 3'd3; gw_val = 1; wr(0, 2, 5, 32'hDEAD_0007, 3);
    step("R7 same");
    clear_in();
    step("R7 still old");
    wr(0, 2, 5, 32'hDEAD_0077, 3);
    step("R7 write");
    clear_in();
    gw_en = 1; gw_addr = 3'd0; gw_val = 0;
    step("R7 addr0");
    clear_in(); wr(5, 3, 1, 32'h0000_0A0A, 0); rd(3, 1);
    step("R6 guard0");
    clear_in();
    step("R6 guard0 read");
    // R8: units 1 and 4 clash on file 7
    wr(4, 7, 6, 32'h4444_4444, 0); wr(1, 7, 6, 32'h1111_1111, 0); rd(7, 6);
    step("R8 clash");
    clear_in();
    step("R8 winner");
    step("R8 sticky");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      for (int u = 0; u < NU; u++) begin
        wr_en[u] = ($urandom % 4) != 0;
        wr_data[u*DW +: DW] = $urandom;
        wr_guard[u*GW +: GW] = GW'(($urandom % 3 == 0) ? $urandom : 0);
        for (int f = 0; f < NR; f++) begin
          wr_dest[u*NR+f] = ($urandom % 10) == 0;
          wr_addr[(u*NR+f)*AWM +: AWM] = AWM'($urandom);
        end
      end
      gw_en = ($urandom % 4) == 0; gw_addr = GW'($urandom); gw_val = 1'($urandom);
      for (int f = 0; f < NR; f++) rd(f, ($urandom % 6 == 0) ? 15 : int'($urandom % 16));
      step("R2 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule